// File: doc/BRIEF.md
# SCL Clock-Stretch Timeout Monitor

This block sits beside the transaction engine of a two-wire serial bus controller. It watches the filtered SCL input while the engine is running a transfer. When the controller has let SCL go high but the line is still low one reference clock later, a target device is holding the clock. The monitor then asks the engine to pause and raises a wait flag. While the hold lasts it measures its length in programmable units, each a set number of reference clocks long.

The measured length is a 12-bit count that software can read, and it stops at its maximum value. The count is compared with a programmable limit. Once the count is above the limit, a second flag reports that the hold has gone on too long. A third flag reports a stretch that started while the engine was still waiting for the acknowledge bit. Each flag has its own interrupt enable and its own write-1 clear strobe. The single interrupt output combines the enabled flags.

The engine tells the monitor whether a transfer is active, whether it is releasing SCL, and whether it is in the acknowledge window. Register decoding and the bus engine itself are outside this block.

Top module: `scl_stretch_mon`

## Requirements
- R1: After reset, all three flags, `pause_o`, `irq_o` and `stretch_cnt_o` are 0.
- R2: `pause_o` is high in exactly those cycles where all of the following hold: `active_i` is high, `scl_rel_i` is high in this cycle and was high in the previous cycle, and the SCL sample registered at the previous edge is low.
- R3: While `pause_o` is high, `stretch_cnt_o` goes up by one after every `prescale_i` paused cycles. With the value P held constant, the count is k after 1 + k·P clock edges counted from the edge that first registers the stretch condition.
- R4: `stretch_cnt_o` and the prescaler return to 0 at the edge after the registered SCL sample is high, or at any edge where `active_i` is low. Otherwise they hold their value while not paused. The count stops at 4095.
- R5: `wait_flag_o` is set at the clock edge that ends a cycle in which `pause_o` is high.
- R6: `long_flag_o` is set at the clock edge that ends a cycle in which `stretch_cnt_o` is greater than `try_lim_i`.
- R7: Each flag is cleared by a one-cycle pulse on its own clear input. A set condition in the same cycle wins over the clear.
- R8: `clkerr_flag_o` is set at the clock edge that ends a cycle in which `pause_o` and `ack_phase_i` are both high.
- R9: `irq_o` is the OR of (wait flag AND `wait_ie_i`), (long flag AND `long_ie_i`) and (clock-error flag AND `clkerr_ie_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Transaction engine is running a transfer |
| scl_rel_i | input | 1 | Engine is releasing SCL (not pulling it low) |
| scl_in_i | input | 1 | Filtered SCL line level |
| ack_phase_i | input | 1 | Engine is waiting for the acknowledge bit |
| prescale_i | input | 16 | Reference clocks per count unit (0 is not allowed) |
| try_lim_i | input | 12 | Count limit for the too-long flag (0 is not allowed) |
| wait_ie_i | input | 1 | Interrupt enable for the wait flag |
| long_ie_i | input | 1 | Interrupt enable for the too-long flag |
| clkerr_ie_i | input | 1 | Interrupt enable for the clock-error flag |
| wait_clr_i | input | 1 | Write-1 clear for the wait flag |
| long_clr_i | input | 1 | Write-1 clear for the too-long flag |
| clkerr_clr_i | input | 1 | Write-1 clear for the clock-error flag |
| wait_flag_o | output | 1 | A target is holding SCL low |
| long_flag_o | output | 1 | The hold has exceeded the limit |
| clkerr_flag_o | output | 1 | A stretch started during the acknowledge window |
| pause_o | output | 1 | Request to the engine to pause the transfer |
| stretch_cnt_o | output | 12 | Current stretch length in prescaled units |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the exact edge on which each count unit ends. A prescaler that is off by one would show the count one cycle early or late, and the too-long flag would move with it. It runs a stretch long enough to reach the top of the count, where a counter without a stop would wrap to zero. It pulses a clear in the same cycle as a set condition, where a design that gave the clear priority would lose the event. It also checks that a low level driven by the controller itself, or a transfer that is not active, never starts a pause or a count.

// File: rtl/scl_stretch_pkg.sv
package scl_stretch_pkg;
  localparam int unsigned PRE_W  = 16;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned N_FLAG = 3;

  // bit position of each flag inside the flag bank vectors
  typedef enum int unsigned {
    FLG_WAIT   = 0,
    FLG_LONG   = 1,
    FLG_CLKERR = 2
  } flag_idx_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/scl_stretch_det.sv
module scl_stretch_det (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic scl_rel_i,
  input  logic scl_in_i,
  output logic stretch_o,
  output logic scl_high_o
);
  logic scl_q, scl_d;
  logic rel_q, rel_d;

  always_comb begin
    scl_d = scl_in_i;
    rel_d = scl_rel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      rel_q <= 1'b0;
    end else begin
      scl_q <= scl_d;
      rel_q <= rel_d;
    end
  end

  // released last cycle and still released, yet line sampled low
  assign stretch_o  = active_i & scl_rel_i & rel_q & ~scl_q;
  assign scl_high_o = scl_q;
endmodule

// File: rtl/scl_stretch_timer.sv
module scl_stretch_timer #(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] try_lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_en, cnt_en;
  logic             tick;
  logic [PRE_W:0]   pre_inc;

  always_comb begin
    pre_inc = {1'b0, pre_q} + {{PRE_W{1'b0}}, 1'b1};
    tick    = (pre_inc >= {1'b0, prescale_i});
    pre_en  = clear_i | run_i;
    cnt_en  = clear_i | (run_i & tick & (cnt_q != CNT_MAX));
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    if (clear_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run_i) begin
      if (tick) begin
        pre_d = '0;
        cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        pre_d = pre_inc[PRE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign over_o = (cnt_q > try_lim_i);
endmodule

// File: rtl/scl_flag_bank.sv
module scl_flag_bank #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] ie_i,
  output logic [NF-1:0] flag_o,
  output logic          irq_o
);
  logic [NF-1:0] flg_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic d, en;
    always_comb begin
      en = set_i[g] | clr_i[g];
      d  = set_i[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flg_q[g] <= 1'b0;
      else if (en) flg_q[g] <= d;
    end
  end

  assign flag_o = flg_q;
  assign irq_o  = |(flg_q & ie_i);
endmodule

// File: rtl/scl_stretch_mon.sv
module scl_stretch_mon
  import scl_stretch_pkg::*;
#(
  parameter int unsigned PW = PRE_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          scl_rel_i,
  input  logic          scl_in_i,
  input  logic          ack_phase_i,
  input  logic [PW-1:0] prescale_i,
  input  logic [CW-1:0] try_lim_i,
  input  logic          wait_ie_i,
  input  logic          long_ie_i,
  input  logic          clkerr_ie_i,
  input  logic          wait_clr_i,
  input  logic          long_clr_i,
  input  logic          clkerr_clr_i,
  output logic          wait_flag_o,
  output logic          long_flag_o,
  output logic          clkerr_flag_o,
  output logic          pause_o,
  output logic [CW-1:0] stretch_cnt_o,
  output logic          irq_o
);
  logic              rst_n_s;
  logic              stretch, scl_high, over;
  logic [N_FLAG-1:0] fset, fclr, fie, flag;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  scl_stretch_det u_det (
    .clk(clk), .rst_n(rst_n_s), .active_i(active_i),
    .scl_rel_i(scl_rel_i), .scl_in_i(scl_in_i),
    .stretch_o(stretch), .scl_high_o(scl_high)
  );

  scl_stretch_timer #(.PRE_W(PW), .CNT_W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .run_i(stretch),
    .clear_i(scl_high | ~active_i), .prescale_i(prescale_i),
    .try_lim_i(try_lim_i), .cnt_o(stretch_cnt_o), .over_o(over)
  );

  always_comb begin
    fset             = '0;
    fclr             = '0;
    fie              = '0;
    fset[FLG_WAIT]   = stretch;
    fset[FLG_LONG]   = over;
    fset[FLG_CLKERR] = stretch & ack_phase_i;
    fclr[FLG_WAIT]   = wait_clr_i;
    fclr[FLG_LONG]   = long_clr_i;
    fclr[FLG_CLKERR] = clkerr_clr_i;
    fie[FLG_WAIT]    = wait_ie_i;
    fie[FLG_LONG]    = long_ie_i;
    fie[FLG_CLKERR]  = clkerr_ie_i;
  end

  scl_flag_bank #(.NF(N_FLAG)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .set_i(fset), .clr_i(fclr),
    .ie_i(fie), .flag_o(flag), .irq_o(irq_o)
  );

  assign wait_flag_o   = flag[FLG_WAIT];
  assign long_flag_o   = flag[FLG_LONG];
  assign clkerr_flag_o = flag[FLG_CLKERR];
  assign pause_o       = stretch;
endmodule

// File: rtl/scl_stretch_mon_chk.sv
module scl_stretch_mon_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active_i,
  input logic          scl_rel_i,
  input logic          ack_phase_i,
  input logic [CW-1:0] try_lim_i,
  input logic          wait_clr_i,
  input logic          wait_flag_o,
  input logic          long_flag_o,
  input logic          clkerr_flag_o,
  input logic          pause_o,
  input logic [CW-1:0] stretch_cnt_o,
  input logic          irq_o
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  assert_pause_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_o |-> (active_i && scl_rel_i));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stretch_cnt_o == $past(stretch_cnt_o) ||
              stretch_cnt_o == $past(stretch_cnt_o) + 1'b1 ||
              stretch_cnt_o == '0));

  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_cnt_o == MAXV && pause_o) |=> (stretch_cnt_o == MAXV));

  assert_wait_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_o |=> wait_flag_o);

  assert_long_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_cnt_o > try_lim_i) |=> long_flag_o);

  assert_wait_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_clr_i && !pause_o) |=> !wait_flag_o);

  assert_clkerr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_o && ack_phase_i) |=> clkerr_flag_o);

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (wait_flag_o || long_flag_o || clkerr_flag_o));
endmodule

bind scl_stretch_mon scl_stretch_mon_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active_i(active_i), .scl_rel_i(scl_rel_i),
  .ack_phase_i(ack_phase_i), .try_lim_i(try_lim_i), .wait_clr_i(wait_clr_i),
  .wait_flag_o(wait_flag_o), .long_flag_o(long_flag_o),
  .clkerr_flag_o(clkerr_flag_o), .pause_o(pause_o),
  .stretch_cnt_o(stretch_cnt_o), .irq_o(irq_o)
);

// File: tb/scl_stretch_mon_tb.sv
`timescale 1ns/1ps
module scl_stretch_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        active = 1'b0, rel = 1'b1, scl_in = 1'b1, ack = 1'b0;
  logic [15:0] pre = 16'd1;
  logic [11:0] lim = 12'd1;
  logic        wie = 1'b0, lie = 1'b0, cie = 1'b0;
  logic        wclr = 1'b0, lclr = 1'b0, cclr = 1'b0;
  logic        wfl, lfl, cfl, pause, irq;
  logic [11:0] cnt;
  int          errors = 0, checks = 0;
  bit          model_on = 1'b0;

  always #2.5 clk = ~clk;

  scl_stretch_mon u_dut (
    .clk(clk), .rst_n(rst_n), .active_i(active), .scl_rel_i(rel),
    .scl_in_i(scl_in), .ack_phase_i(ack), .prescale_i(pre), .try_lim_i(lim),
    .wait_ie_i(wie), .long_ie_i(lie), .clkerr_ie_i(cie),
    .wait_clr_i(wclr), .long_clr_i(lclr), .clkerr_clr_i(cclr),
    .wait_flag_o(wfl), .long_flag_o(lfl), .clkerr_flag_o(cfl),
    .pause_o(pause), .stretch_cnt_o(cnt), .irq_o(irq)
  );

  // reference built from the requirements
  logic        m_sq, m_rq;
  logic [15:0] m_pre;
  logic [11:0] m_cnt;
  logic [2:0]  m_fl;

  function automatic logic m_pause();
    return active && rel && m_rq && !m_sq;
  endfunction

  function automatic logic m_irq();
    return (m_fl[0] && wie) || (m_fl[1] && lie) || (m_fl[2] && cie);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sq <= 1'b1; m_rq <= 1'b0; m_pre <= '0; m_cnt <= '0; m_fl <= '0;
    end else begin
      m_fl <= (m_fl & ~{cclr, lclr, wclr}) |
              {m_pause() && ack, m_cnt > lim, m_pause()};
      m_sq <= scl_in;
      m_rq <= rel;
      if (m_sq || !active) begin
        m_pre <= '0; m_cnt <= '0;
      end else if (m_pause()) begin
        if ({1'b0, m_pre} + 17'd1 >= {1'b0, pre}) begin
          m_pre <= '0;
          if (m_cnt != 12'hFFF) m_cnt <= m_cnt + 12'd1;
        end else m_pre <= m_pre + 16'd1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    chk("R2 pause", pause, m_pause());
    chk("R3 count", cnt, m_cnt);
    chk("R5 wait flag", wfl, m_fl[0]);
    chk("R6 long flag", lfl, m_fl[1]);
    chk("R8 clkerr flag", cfl, m_fl[2]);
    chk("R9 irq", irq, m_irq());
  endtask

  // advance one cycle: check at negedge, then drive
  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (model_on) chk_model();
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int unsigned seed;
    int          left;
    seed = $urandom(32'd7051);
    left = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 wait", wfl, 0); chk("R1 long", lfl, 0); chk("R1 clkerr", cfl, 0);
    chk("R1 pause", pause, 0); chk("R1 cnt", cnt, 0); chk("R1 irq", irq, 0);
    model_on = 1'b1;

    // directed R3/R6: P=3, L=2
    pre = 16'd3; lim = 12'd2; active = 1'b1; rel = 1'b1; scl_in = 1'b0;
    tick_n(10);
    chk("R3 count after 10 edges", cnt, 3);
    chk("R6 long flag not yet", lfl, 0);
    tick_n(1);
    chk("R6 long flag set", lfl, 1);
    // R7 clear while stretch still active: set wins
    wclr = 1'b1; tick_n(1); wclr = 1'b0;
    chk("R7 set over clear", wfl, 1);
    // release the line, then clear
    scl_in = 1'b1; tick_n(2);
    chk("R4 count cleared on high", cnt, 0);
    wclr = 1'b1; lclr = 1'b1; tick_n(1); wclr = 1'b0; lclr = 1'b0;
    chk("R7 wait cleared", wfl, 0);
    chk("R7 long cleared", lfl, 0);
    // controller drives SCL low itself: no pause
    rel = 1'b0; scl_in = 1'b0; tick_n(6);
    chk("R2 own low no pause", pause, 0);
    chk("R4 own low no count", cnt, 0);
    // inactive engine ignores a stretch
    active = 1'b0; rel = 1'b1; tick_n(6);
    chk("R2 inactive no pause", pause, 0);
    chk("R5 inactive no wait", wfl, 0);

    // R4 saturation: P=1, long stretch
    active = 1'b1; pre = 16'd1; lim = 12'd4094; scl_in = 1'b0; rel = 1'b1;
    tick_n(4100);
    chk("R4 saturated count", cnt, 4095);
    chk("R6 long at top", lfl, 1);
    scl_in = 1'b1; tick_n(3);
    wclr = 1'b1; lclr = 1'b1; cclr = 1'b1; tick_n(1);
    wclr = 1'b0; lclr = 1'b0; cclr = 1'b0;

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      pre = 16'(1 + $urandom % 4);
      lim = 12'(1 + $urandom % 8);
      {wie, lie, cie} = 3'($urandom);
      for (int c = 0; c < 2000; c++) begin
        tick_n(1);
        if (left > 0) begin
          rel = 1'b1; scl_in = 1'b0; left--;
        end else begin
          int r;
          r = $urandom % 16;
          if (r < 5) begin rel = 1'b0; scl_in = 1'b0; end
          else if (r == 5) begin left = 1 + $urandom % 20; rel = 1'b1; scl_in = 1'b0; end
          else begin rel = 1'b1; scl_in = 1'b1; end
        end
        if ($urandom % 64 == 0) active = ~active;
        ack  = ($urandom % 8 == 0);
        wclr = ($urandom % 12 == 0);
        lclr = ($urandom % 12 == 0);
        cclr = ($urandom % 12 == 0);
      end
    end
    tick_n(1);
    report();
    $finish;
  end
endmodule